// File: doc/BRIEF.md
# FPGA Passive Configuration Sequencer

This block is a hardware master that programs a target FPGA from a bitstream. The bitstream arrives as bytes on a valid/ready stream. A start pulse gives the transfer mode and the total number of bytes. The sequencer then runs the whole pin-level procedure on the target:

- It pulses the active-low configuration reset for a set time.
- It waits a settling time.
- It clocks the data out, either one bit per clock or one byte per clock.
- It checks the target's status line before every byte.
- It gives one extra clock edge after the last byte, waits again, and reads the target's done line.

Three transfer modes share one state machine. Serial mode sends each byte as eight clocked bits on data pin 0, least significant bit first. Parallel mode puts the whole byte on the 8-bit bus and gives one clock. Secure parallel mode does the same and then gives three more clocks with the data held.

All delays are counted in system clocks, derived from the clock frequency and microsecond parameters. While the transfer runs the block shows busy. When it stops it shows exactly one of done_ok or fail. On a failure by the target it also raises abort. byte_count tells how many bytes were sent.

Top module: `cfgld_loader`

## Requirements
- R1: After an accepted start, cfg_nreset is driven low for exactly RST_US microseconds' worth of system clocks (at least one), then driven high.
- R2: cfg_clk stays low while cfg_nreset is low. The first rising edge of cfg_clk comes no sooner than WAIT_US microseconds' worth of system clocks after cfg_nreset rises.
- R3: With mode 0 (serial), each byte gives eight rising edges of cfg_clk. cfg_data[0] carries bit 0 first and bit 7 last, and cfg_data[7:1] is zero.
- R4: With mode 1 (parallel), each byte gives one rising edge of cfg_clk with the full byte on cfg_data.
- R5: With mode 2 (secure parallel), each byte gives four rising edges of cfg_clk, all with the same byte on cfg_data.
- R6: tgt_status is sampled before each byte is taken. If it is low, no byte is taken and no further clock edges follow. fail and abort_o rise, and byte_count equals the number of bytes fully sent.
- R7: After the last byte one more rising edge is driven. cfg_clk then stays high for exactly WAIT_US microseconds' worth of system clocks, and then tgt_done is sampled. High gives done_ok. Low gives fail with abort_o. In both cases byte_count equals the length.
- R8: A start with length 0, or with mode 3, gives fail in the next cycle. cfg_nreset stays high, no clock edge occurs, abort_o stays low and byte_count is 0.
- R9: While s_valid is low during the data phase, cfg_clk is held low and the sequencer waits for any length of time without failing.
- R10: At most one of busy, done_ok and fail is high. A start pulse while busy has no effect on the running transfer.
- R11: After reset: busy, done_ok, fail, abort_o, cfg_clk and s_ready are low, cfg_nreset is high, and byte_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, one cycle, accepted only when not busy |
| mode | input | 2 | 0 serial, 1 parallel, 2 secure parallel, 3 rejected |
| length | input | LEN_W | Number of bitstream bytes |
| s_valid | input | 1 | Upstream byte valid |
| s_data | input | 8 | Upstream byte |
| s_ready | output | 1 | Byte accepted this cycle when high with s_valid |
| cfg_nreset | output | 1 | Active-low configuration reset to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | 8 | Configuration data to the target |
| tgt_status | input | 1 | Target status, high means healthy |
| tgt_done | input | 1 | Target configuration-complete flag |
| abort_o | output | 1 | Target-side failure, held until the next start |
| busy | output | 1 | Transfer in progress |
| done_ok | output | 1 | Last transfer completed with done high |
| fail | output | 1 | Last transfer or request failed |
| byte_count | output | LEN_W | Bytes fully sent in the current or last transfer |

## Verification
Faults in the state register or in the sub-counters show up at the target pins within one byte time. If the bit index or the extra-pulse counter is wrong, the number of cfg_clk rising edges per byte changes, or the bit on cfg_data[0] changes, at the first byte. If the timer is wrong, the reset pulse or the high time before done is sampled has the wrong length, and this can be measured in whole cycles. If the byte counter or the end test is wrong, the final edge moves, or the reported byte_count differs from the length or from the number of bytes sent before status dropped.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [1:0] {
        MODE_SERIAL  = 2'd0,
        MODE_PAR     = 2'd1,
        MODE_PAR_SEC = 2'd2,
        MODE_BAD     = 2'd3
    } cfg_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OK,
        ST_ERR,
        ST_RST_LO,
        ST_RST_WT,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_DWAIT
    } cfg_state_e;

endpackage

// File: rtl/cfgld_timer.sv
// Down counter: load sets the count, otherwise it counts to zero and holds.
module cfgld_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfgld_pin_enc.sv
// Maps the held byte onto the data pins: one bit on lane 0 or the whole byte.
module cfgld_pin_enc (
    input  logic       serial,
    input  logic       active,
    input  logic [7:0] byte_in,
    input  logic [2:0] bit_sel,
    output logic [7:0] pins
);
    for (genvar g = 0; g < 8; g++) begin : g_lane
        if (g == 0) begin : g_lane0
            assign pins[g] = active & (serial ? byte_in[bit_sel] : byte_in[0]);
        end else begin : g_upper
            assign pins[g] = active & ~serial & byte_in[g];
        end
    end
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader #(
    parameter int CLK_HZ   = 100_000_000,
    parameter int RST_US   = 5,
    parameter int WAIT_US  = 100,
    parameter int HALF_CYC = 1,
    parameter int LEN_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] length,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    output logic             cfg_nreset,
    output logic             cfg_clk,
    output logic [7:0]       cfg_data,
    input  logic             tgt_status,
    input  logic             tgt_done,
    output logic             abort_o,
    output logic             busy,
    output logic             done_ok,
    output logic             fail,
    output logic [LEN_W-1:0] byte_count
);
    import cfgld_pkg::*;

    localparam int CYC_US   = (CLK_HZ + 999_999) / 1_000_000;
    localparam int RST_CYC  = (CYC_US * RST_US  < 1) ? 1 : CYC_US * RST_US;
    localparam int WAIT_CYC = (CYC_US * WAIT_US < 1) ? 1 : CYC_US * WAIT_US;
    localparam int HALF     = (HALF_CYC < 1) ? 1 : HALF_CYC;
    localparam int MAX_A    = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
    localparam int MAX_CYC  = (MAX_A > HALF) ? MAX_A : HALF;
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] T_RST  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] T_WAIT = TW'(WAIT_CYC - 1);
    localparam logic [TW-1:0] T_HALF = TW'(HALF - 1);

    typedef struct packed {
        cfg_state_e       st;
        cfg_mode_e        mode;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic [7:0]       sh;
        logic [2:0]       bit_i;
        logic [1:0]       extra;
        logic             nrst;
        logic             cclk;
        logic             abrt;
        logic             ok;
        logic             bad;
    } seq_t;

    seq_t          d, q;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          pins_on;

    cfgld_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.st)
            ST_IDLE, ST_OK, ST_ERR: begin
                if (start) begin
                    d.ok   = 1'b0;
                    d.bad  = 1'b0;
                    d.abrt = 1'b0;
                    d.cnt  = '0;
                    d.len  = length;
                    d.mode = cfg_mode_e'(mode);
                    if (length == '0 || cfg_mode_e'(mode) == MODE_BAD) begin
                        d.st  = ST_ERR;
                        d.bad = 1'b1;
                    end else begin
                        d.st     = ST_RST_LO;
                        d.nrst   = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = T_RST;
                    end
                end
            end
            ST_RST_LO: begin
                if (tmr_exp) begin
                    d.nrst   = 1'b1;
                    d.st     = ST_RST_WT;
                    tmr_load = 1'b1;
                    tmr_val  = T_WAIT;
                end
            end
            ST_RST_WT: begin
                if (tmr_exp) d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (!tgt_status) begin
                    d.st   = ST_ERR;
                    d.bad  = 1'b1;
                    d.abrt = 1'b1;
                end else if (s_valid) begin
                    d.sh     = s_data;
                    d.bit_i  = '0;
                    d.extra  = (q.mode == MODE_PAR_SEC) ? 2'd3 : 2'd0;
                    d.st     = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    d.cclk   = 1'b1;
                    d.st     = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    d.cclk = 1'b0;
                    if (q.mode == MODE_SERIAL && q.bit_i != 3'd7) begin
                        d.bit_i  = q.bit_i + 3'd1;
                        d.st     = ST_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = T_HALF;
                    end else if (q.extra != 2'd0) begin
                        d.extra  = q.extra - 2'd1;
                        d.st     = ST_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = T_HALF;
                    end else begin
                        d.cnt = q.cnt + LEN_W'(1);
                        if (q.cnt + LEN_W'(1) == q.len) begin
                            d.st     = ST_TAIL;
                            tmr_load = 1'b1;
                            tmr_val  = T_HALF;
                        end else begin
                            d.st = ST_FETCH;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_exp) begin
                    d.cclk   = 1'b1;
                    d.st     = ST_DWAIT;
                    tmr_load = 1'b1;
                    tmr_val  = T_WAIT;
                end
            end
            ST_DWAIT: begin
                if (tmr_exp) begin
                    d.cclk = 1'b0;
                    if (tgt_done) begin
                        d.ok = 1'b1;
                        d.st = ST_OK;
                    end else begin
                        d.bad  = 1'b1;
                        d.abrt = 1'b1;
                        d.st   = ST_ERR;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.mode <= MODE_SERIAL;
            q.nrst <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pins_on = (q.st == ST_LOW) || (q.st == ST_HIGH) ||
                     (q.st == ST_TAIL) || (q.st == ST_DWAIT);

    cfgld_pin_enc u_enc (
        .serial  (q.mode == MODE_SERIAL),
        .active  (pins_on),
        .byte_in (q.sh),
        .bit_sel (q.bit_i),
        .pins    (cfg_data)
    );

    assign s_ready    = (q.st == ST_FETCH) && tgt_status;
    assign cfg_nreset = q.nrst;
    assign cfg_clk    = q.cclk;
    assign abort_o    = q.abrt;
    assign done_ok    = q.ok;
    assign fail       = q.bad;
    assign byte_count = q.cnt;
    assign busy       = !((q.st == ST_IDLE) || (q.st == ST_OK) || (q.st == ST_ERR));
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] length,
    input logic             s_ready,
    input logic             cfg_nreset,
    input logic             cfg_clk,
    input logic             tgt_status,
    input logic             abort_o,
    input logic             busy,
    input logic             done_ok,
    input logic             fail,
    input logic [LEN_W-1:0] byte_count
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy, done_ok, fail}) <= 1); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done_ok || fail)); // R10
    AST_REST_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(byte_count)); // R10
    AST_CLK_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_nreset |-> !cfg_clk); // R2
    AST_READY_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> tgt_status); // R6
    AST_ABORT_IMPLIES_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> fail); // R6
    AST_ZERO_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && length == '0) |=> (fail && cfg_nreset && !abort_o)); // R8
endmodule

bind cfgld_loader cfgld_checker #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .length     (length),
    .s_ready    (s_ready),
    .cfg_nreset (cfg_nreset),
    .cfg_clk    (cfg_clk),
    .tgt_status (tgt_status),
    .abort_o    (abort_o),
    .busy       (busy),
    .done_ok    (done_ok),
    .fail       (fail),
    .byte_count (byte_count)
);

// File: tb/tb_cfgld_loader.sv
module tb_cfgld_loader;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 5;
    localparam int WAIT_CYC   = 20;
    localparam int HALF       = 2;
    localparam int LW         = 8;

    logic          clk = 0, rst_n = 0, start = 0;
    logic [1:0]    mode = 0;
    logic [LW-1:0] length = 0;
    logic          s_valid = 0;
    logic [7:0]    s_data = 0;
    logic          s_ready, cfg_nreset, cfg_clk;
    logic [7:0]    cfg_data;
    logic          tgt_status = 1, tgt_done = 1;
    logic          abort_o, busy, done_ok, fail;
    logic [LW-1:0] byte_count;

    cfgld_loader #(
        .CLK_HZ(1_000_000), .RST_US(RST_CYC), .WAIT_US(WAIT_CYC),
        .HALF_CYC(HALF), .LEN_W(LW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .length(length),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .cfg_nreset(cfg_nreset), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
        .tgt_status(tgt_status), .tgt_done(tgt_done), .abort_o(abort_o),
        .busy(busy), .done_ok(done_ok), .fail(fail), .byte_count(byte_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0, cycles = 0;
    logic [7:0] src [0:63];
    int   run_len = 0, fail_at = -1, stall_at = -1, stall_len = 0;
    logic clr = 0;
    int   idx = 0;
    int   n_edges = 0, lo_rst = 0, gap = 0, hi_run = 0, max_hi = 0;
    int   stall_cnt = 0, e_mid = -1, e_end = -2;
    logic prev_clk = 0, stall_clk = 1, stall_busy = 0;
    logic [7:0] cap [0:255];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (clr) idx <= 0;
        else if (s_valid && s_ready) idx <= idx + 1;
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            chk(0, "watchdog", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Pin monitor and upstream driver, all away from the active edge
    always @(negedge clk) begin
        if (clr) begin
            n_edges = 0; lo_rst = 0; gap = 0; hi_run = 0; max_hi = 0;
            stall_cnt = stall_len; e_mid = -1; e_end = -2; prev_clk = 0;
            stall_clk = 1; stall_busy = 0;
        end else begin
            if (cfg_clk && !prev_clk && n_edges < 256) begin
                cap[n_edges] = cfg_data;
                n_edges++;
            end
            prev_clk = cfg_clk;
            if (!cfg_nreset) lo_rst++;
            if (cfg_nreset && busy && n_edges == 0) gap++;
            if (cfg_clk) begin
                hi_run++;
                if (hi_run > max_hi) max_hi = hi_run;
            end else hi_run = 0;
            if (idx == stall_at && stall_cnt > 0) begin
                stall_cnt--;
                if (stall_cnt == 200) e_mid = n_edges;
                if (stall_cnt == 1) begin
                    e_end = n_edges; stall_clk = cfg_clk; stall_busy = busy;
                end
            end
        end
        s_valid    = (idx < run_len) && !(idx == stall_at && stall_cnt > 0);
        s_data     = src[(idx < 64) ? idx : 0];
        tgt_status = !(fail_at >= 0 && idx >= fail_at);
    end

    task automatic run(input int m, input int len, input bit dn, input int fa,
                       input int sa, input bit poke);
        int per, exp_edges, w, n_cmp, bad_at;
        bit poked;
        string dreq;
        @(negedge clk);
        for (int i = 0; i < 64; i++) src[i] = 8'(i * 37 + len * 11 + m * 5 + 90);
        run_len = len; fail_at = fa; stall_at = sa; stall_len = (sa >= 0) ? 300 : 0;
        tgt_done = dn; clr = 1;
        @(negedge clk); @(negedge clk);
        clr = 0; start = 1; mode = 2'(m); length = LW'(len);
        @(negedge clk);
        start = 0; poked = 0; w = 0;
        while (!(done_ok || fail) && w < 20000) begin
            if (poke && !poked && idx >= 2) begin
                start = 1; mode = 2'd3; length = '0; poked = 1;
                @(negedge clk);
                start = 0;
            end
            @(negedge clk);
            w++;
        end
        chk(w < 20000, "run timeout", w, 20000);
        per = (m == 0) ? 8 : ((m == 1) ? 1 : 4);
        dreq = (m == 0) ? "R3" : ((m == 1) ? "R4" : "R5");
        if (len == 0 || m == 3) begin
            // R8: rejected request, pins untouched
            chk(fail && !busy && !done_ok && !abort_o && byte_count == 0 && w == 0,
                "R8 reject flags", {fail, busy, done_ok, abort_o}, 4'b1000);
            chk(n_edges == 0 && lo_rst == 0, "R8 pins untouched", n_edges + lo_rst, 0);
            return;
        end
        if (fa >= 0 && fa < len) begin
            exp_edges = per * fa;
            chk(fail && abort_o && !done_ok, "R6 status abort", {fail, abort_o, done_ok}, 3'b110);
            chk(int'(byte_count) == fa, "R6 byte count", byte_count, fa);
            chk(n_edges == exp_edges, "R6 edges stop", n_edges, exp_edges);
            n_cmp = exp_edges;
        end else begin
            exp_edges = per * len + 1;
            chk(n_edges == exp_edges, {dreq, " edge total"}, n_edges, exp_edges);
            chk(lo_rst == RST_CYC, "R1 reset pulse", lo_rst, RST_CYC);
            chk(gap >= WAIT_CYC, "R2 first edge delay", gap, WAIT_CYC);
            chk(max_hi == WAIT_CYC, "R7 final high hold", max_hi, WAIT_CYC);
            chk(int'(byte_count) == len, "R7 byte count", byte_count, len);
            if (dn) chk(done_ok && !fail && !abort_o && !busy, "R7 success",
                        {done_ok, fail, abort_o}, 3'b100);
            else    chk(!done_ok && fail && abort_o && !busy, "R7 done low",
                        {done_ok, fail, abort_o}, 3'b011);
            n_cmp = per * len;
        end
        bad_at = -1;
        for (int k = 0; k < n_cmp && k < 256; k++) begin
            logic [7:0] e;
            e = (m == 0) ? {7'b0, src[k / 8][k % 8]} : src[k / per];
            if (cap[k] !== e && bad_at < 0) bad_at = k;
        end
        if (n_cmp > 0)
            chk(bad_at < 0, {dreq, " data sequence"}, (bad_at < 0) ? 0 : int'(cap[bad_at]),
                (bad_at < 0) ? 0 : bad_at);
        if (sa >= 0)
            chk(e_mid == e_end && stall_clk == 0 && stall_busy == 1, "R9 stall holds clock",
                e_end - e_mid, 0);
        if (poke)
            chk(poked && done_ok && !fail, "R10 start ignored while busy", fail, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done_ok && !fail && !abort_o && !cfg_clk && !s_ready,
            "R11 reset flags", {busy, done_ok, fail, abort_o, cfg_clk, s_ready}, 0);
        chk(cfg_nreset == 1 && byte_count == 0, "R11 reset pins", byte_count, 0);
        // sweep of modes and lengths
        for (int m = 0; m < 3; m++) begin
            run(m, 1, 1, -1, -1, 0);
            run(m, 2, 1, -1, -1, 0);
            run(m, 5, 1, -1, -1, 0);
            run(m, 16, 1, -1, -1, 0);
        end
        run(0, 3, 0, -1, -1, 0);   // R7 done low
        run(2, 2, 0, -1, -1, 0);
        run(1, 6, 1, 3, -1, 0);    // R6 mid-stream status drop
        run(0, 4, 1, 0, -1, 0);    // R6 status low before first byte
        run(2, 5, 1, 4, -1, 0);
        run(1, 0, 1, -1, -1, 0);   // R8 zero length
        run(3, 4, 1, -1, -1, 0);   // R8 unsupported mode
        run(0, 3, 1, -1, 1, 0);    // R9 stall
        run(2, 3, 1, -1, 1, 0);
        run(1, 5, 1, -1, -1, 1);   // R10 start while busy
        run(1, 2, 1, -1, -1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule